// File: doc/BRIEF.md
# Processor Slot Presence Register Window

This block keeps a presence bit for each processor slot, up to 256 slots, and shows them to firmware through a 32-byte I/O window. Firmware reads the bytes to learn which slots are populated. Platform logic reports a newly inserted processor on a plug request port. The block then sets that slot's bit and sends a one-cycle event status pulse to the general-purpose event logic.

Writes into the window never alter the bitmap. There is one exception to "writes do nothing": a byte write of zero at offset zero. Firmware uses it to give up this legacy interface. The block also gives up the legacy interface when a plug request names a slot beyond the window. In that case no bit is set and the request goes out on a forwarding port toward a separate, newer hotplug mechanism. The switch is one-way until reset. Once it has happened, the window no longer answers reads.

Top module: `cpu_presence_window`

## Requirements
- R1: During and right after reset, the bitmap equals the `init_present` vector, `legacy_off` is 0, and `gpe_status_pulse`, `modern_plug_valid` and `rsp_valid` are 0.
- R2: Slot N is held in bit (N mod 8) of the byte at offset (N div 8).
- R3: A read request is accepted with `req_ready` high. `rsp_valid` is high exactly one cycle later. `req_size` value s selects s+1 bytes. Byte lane i of `rsp_rdata` (bits 8i+7:8i) holds the presence byte at offset `req_addr`+i. Lanes above the size, and lanes past offset 31, read as zero.
- R4: No write changes any presence bit.
- R5: A write sets `legacy_off` when `req_addr` is 0 and data lane 0 (`req_wdata[7:0]`) is zero, for any size. Every other write leaves `legacy_off` unchanged.
- R6: A plug request with `plug_id` below 256 ORs in that slot's bit. The next cycle, `gpe_status_pulse` is high for one cycle.
- R7: A plug request with `plug_id` of 256 or more changes no bit and gives no event pulse. The next cycle, `modern_plug_valid` is high for one cycle with `modern_plug_id` equal to the request's identifier, and `legacy_off` is set.
- R8: Once set, `legacy_off` stays set until reset.
- R9: A read accepted while `legacy_off` is set produces no `rsp_valid`, and `rsp_rdata` stays zero.
- R10: A plug request and a bus write in the same cycle both take effect: the slot bit and event pulse from the plug, and the mode switch from a qualifying write.
- R11: A read accepted in the same cycle as a plug request returns the bitmap as it was before that plug.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_present | input | 256 | Presence bits loaded during reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always accepting) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset within the window |
| req_size | input | 2 | Access size minus one, in bytes |
| req_wdata | input | 32 | Write data, lane 0 at the lowest offset |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, little-endian lanes |
| plug_valid | input | 1 | Processor plug request |
| plug_id | input | 9 | Identifier of the plugged processor |
| gpe_status_pulse | output | 1 | One-cycle hotplug event status |
| modern_plug_valid | output | 1 | Forwarded plug request, out-of-range identifier |
| modern_plug_id | output | 9 | Identifier of the forwarded request |
| legacy_off | output | 1 | Sticky flag: legacy window abandoned |

## Verification
The hardest case to reach is a plug request arriving in the same cycle as a bus access. This matters twice. A read in that cycle must return the old byte. A zero write at offset zero in that cycle must still set the flag while the plug's bit and pulse also go through. The stimulus drives these cycles on purpose, plug and read together and plug and write together, on top of randomized plug/read/write traffic. The mode switch hides the bitmap from reads, so the bench checks bitmap contents before any switch. It then resets between the three ways of switching: zero write, out-of-range plug, and combined plug plus write.

// File: rtl/cpw_pkg.sv
package cpw_pkg;

    localparam int BUS_LANES = 4;
    localparam int BUS_W     = BUS_LANES * 8;

    typedef enum logic [1:0] {
        PLUG_IDLE = 2'd0,
        PLUG_SET  = 2'd1,
        PLUG_FWD  = 2'd2
    } plug_kind_e;

    typedef struct packed {
        logic             valid;
        logic [BUS_W-1:0] data;
    } rd_rsp_t;

    function automatic logic lane_active(input int unsigned lane, input logic [1:0] size);
        return lane <= int'(size);
    endfunction

    function automatic logic [7:0] lane_of(input logic [BUS_W-1:0] word, input int unsigned lane);
        return word[lane*8 +: 8];
    endfunction

endpackage

// File: rtl/cpw_bitmap.sv
module cpw_bitmap #(
    parameter int SLOTS = 256,
    parameter int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SLOTS-1:0] init_bits,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    output logic [SLOTS-1:0] bits
);
    for (genvar b = 0; b < SLOTS; b++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                bits[b] <= init_bits[b];
            end else if (set_en && (set_idx == IDX_W'(b))) begin
                bits[b] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpw_plug_ctrl.sv
module cpw_plug_ctrl
    import cpw_pkg::*;
#(
    parameter int SLOTS = 256,
    parameter int ID_W  = 9,
    parameter int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             plug_valid,
    input  logic [ID_W-1:0]  plug_id,
    output logic             set_en,
    output logic [IDX_W-1:0] set_idx,
    output logic             oob_now,
    output logic             gpe_pulse,
    output logic             fwd_valid,
    output logic [ID_W-1:0]  fwd_id
);
    localparam int WIDE_W = ID_W + IDX_W + 1;

    logic [WIDE_W-1:0] id_wide;
    plug_kind_e        kind;

    always_comb begin
        id_wide = WIDE_W'(plug_id);
        kind    = PLUG_IDLE;
        if (plug_valid) begin
            kind = (id_wide < WIDE_W'(SLOTS)) ? PLUG_SET : PLUG_FWD;
        end
    end

    assign set_en  = (kind == PLUG_SET);
    assign set_idx = id_wide[IDX_W-1:0];
    assign oob_now = (kind == PLUG_FWD);

    always_ff @(posedge clk) begin
        if (rst) begin
            gpe_pulse <= 1'b0;
            fwd_valid <= 1'b0;
            fwd_id    <= '0;
        end else begin
            gpe_pulse <= (kind == PLUG_SET);
            fwd_valid <= (kind == PLUG_FWD);
            if (kind == PLUG_FWD) begin
                fwd_id <= plug_id;
            end
        end
    end
endmodule

// File: rtl/cpw_bus_port.sv
module cpw_bus_port
    import cpw_pkg::*;
#(
    parameter int SLOTS     = 256,
    parameter int WIN_BYTES = SLOTS / 8,
    parameter int OFS_W     = $clog2(WIN_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SLOTS-1:0] bits,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [OFS_W-1:0] req_addr,
    input  logic [1:0]       req_size,
    input  logic [BUS_W-1:0] req_wdata,
    input  logic             oob_now,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata,
    output logic             mode_flag
);
    localparam int SUM_W = OFS_W + 2;

    logic [7:0]       win_byte [WIN_BYTES];
    logic [BUS_W-1:0] rd_word;
    logic             zero_wr;
    logic             rd_go;
    rd_rsp_t          rsp_q;

    for (genvar k = 0; k < WIN_BYTES; k++) begin : g_bytes
        assign win_byte[k] = bits[k*8 +: 8];
    end

    for (genvar i = 0; i < BUS_LANES; i++) begin : g_lane
        logic [SUM_W-1:0] ofs;
        logic             hit;
        assign ofs = SUM_W'(req_addr) + SUM_W'(i);
        assign hit = lane_active(i, req_size) && (ofs < SUM_W'(WIN_BYTES));
        assign rd_word[i*8 +: 8] = hit ? win_byte[ofs[OFS_W-1:0]] : 8'h00;
    end

    assign zero_wr = req_valid && req_write && (req_addr == '0)
                     && (lane_of(req_wdata, 0) == 8'h00);
    assign rd_go   = req_valid && !req_write && !mode_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_flag <= 1'b0;
            rsp_q     <= '0;
        end else begin
            mode_flag  <= mode_flag | zero_wr | oob_now;
            rsp_q.valid <= rd_go;
            rsp_q.data  <= rd_go ? rd_word : '0;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;
endmodule

// File: rtl/cpu_presence_window.sv
module cpu_presence_window
    import cpw_pkg::*;
#(
    parameter int SLOTS     = 256,
    parameter int ID_W      = 9,
    parameter int WIN_BYTES = SLOTS / 8,
    parameter int OFS_W     = $clog2(WIN_BYTES),
    parameter int IDX_W     = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SLOTS-1:0] init_present,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [OFS_W-1:0] req_addr,
    input  logic [1:0]       req_size,
    input  logic [BUS_W-1:0] req_wdata,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata,
    input  logic             plug_valid,
    input  logic [ID_W-1:0]  plug_id,
    output logic             gpe_status_pulse,
    output logic             modern_plug_valid,
    output logic [ID_W-1:0]  modern_plug_id,
    output logic             legacy_off
);
    logic [SLOTS-1:0] bitmap;
    logic             set_en;
    logic [IDX_W-1:0] set_idx;
    logic             oob_now;

    assign req_ready = 1'b1;

    cpw_plug_ctrl #(.SLOTS(SLOTS), .ID_W(ID_W), .IDX_W(IDX_W)) u_plug (
        .clk       (clk),
        .rst       (rst),
        .plug_valid(plug_valid),
        .plug_id   (plug_id),
        .set_en    (set_en),
        .set_idx   (set_idx),
        .oob_now   (oob_now),
        .gpe_pulse (gpe_status_pulse),
        .fwd_valid (modern_plug_valid),
        .fwd_id    (modern_plug_id)
    );

    cpw_bitmap #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_map (
        .clk      (clk),
        .rst      (rst),
        .init_bits(init_present),
        .set_en   (set_en),
        .set_idx  (set_idx),
        .bits     (bitmap)
    );

    cpw_bus_port #(.SLOTS(SLOTS), .WIN_BYTES(WIN_BYTES), .OFS_W(OFS_W)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .bits     (bitmap),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_size (req_size),
        .req_wdata(req_wdata),
        .oob_now  (oob_now),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .mode_flag(legacy_off)
    );
endmodule

// File: rtl/cpw_checker.sv
module cpw_checker #(
    parameter int SLOTS = 256,
    parameter int ID_W  = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic             plug_valid,
    input logic [ID_W-1:0]  plug_id,
    input logic             gpe_status_pulse,
    input logic             modern_plug_valid,
    input logic [ID_W-1:0]  modern_plug_id,
    input logic             legacy_off,
    input logic             rsp_valid,
    input logic [31:0]      rsp_rdata,
    input logic [SLOTS-1:0] bitmap
);
    AST_BITS_ONLY_RISE: assert property (@(posedge clk) disable iff (rst)
        (bitmap & $past(bitmap)) == $past(bitmap)); // R4

    AST_PULSE_FROM_PLUG: assert property (@(posedge clk) disable iff (rst)
        gpe_status_pulse |-> ($past(plug_valid) && ($past(plug_id) < SLOTS))); // R6

    AST_PULSE_SETS_BIT: assert property (@(posedge clk) disable iff (rst)
        $rose(gpe_status_pulse) |-> bitmap[$past(plug_id) % SLOTS]); // R2

    AST_FWD_FROM_OOB: assert property (@(posedge clk) disable iff (rst)
        modern_plug_valid |-> ($past(plug_valid) && ($past(plug_id) >= SLOTS)
                               && modern_plug_id == $past(plug_id))); // R7

    AST_FWD_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        modern_plug_valid |-> (!gpe_status_pulse && legacy_off)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        legacy_off |=> legacy_off); // R8

    AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid) && !$past(req_write))); // R3

    AST_SILENT_AFTER_SWITCH: assert property (@(posedge clk) disable iff (rst)
        $past(legacy_off) |-> (!rsp_valid && rsp_rdata == 32'h0)); // R9
endmodule

bind cpu_presence_window cpw_checker #(.SLOTS(SLOTS), .ID_W(ID_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .req_valid        (req_valid),
    .req_write        (req_write),
    .plug_valid       (plug_valid),
    .plug_id          (plug_id),
    .gpe_status_pulse (gpe_status_pulse),
    .modern_plug_valid(modern_plug_valid),
    .modern_plug_id   (modern_plug_id),
    .legacy_off       (legacy_off),
    .rsp_valid        (rsp_valid),
    .rsp_rdata        (rsp_rdata),
    .bitmap           (bitmap)
);

// File: tb/tb_cpu_presence_window.sv
`timescale 1ns/1ps
module tb_cpu_presence_window;
    localparam int SLOTS = 256;
    localparam int ID_W  = 9;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [SLOTS-1:0] init_present;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_write = 1'b0;
    logic [4:0]       req_addr  = '0;
    logic [1:0]       req_size  = '0;
    logic [31:0]      req_wdata = '0;
    logic             rsp_valid;
    logic [31:0]      rsp_rdata;
    logic             plug_valid = 1'b0;
    logic [ID_W-1:0]  plug_id    = '0;
    logic             gpe_status_pulse;
    logic             modern_plug_valid;
    logic [ID_W-1:0]  modern_plug_id;
    logic             legacy_off;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [SLOTS-1:0] m_bits;
    bit               m_flag;

    always #2 clk = ~clk;

    cpu_presence_window #(.SLOTS(SLOTS), .ID_W(ID_W)) dut (
        .clk(clk), .rst(rst), .init_present(init_present),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .plug_valid(plug_valid), .plug_id(plug_id),
        .gpe_status_pulse(gpe_status_pulse),
        .modern_plug_valid(modern_plug_valid), .modern_plug_id(modern_plug_id),
        .legacy_off(legacy_off)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int a, input int s);
        logic [31:0] w = '0;
        for (int i = 0; i < 4; i++) begin
            if (i <= s && a + i < SLOTS / 8) w[i*8 +: 8] = m_bits[(a + i) * 8 +: 8];
        end
        return w;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_bits = init_present;
        m_flag = 1'b0;
        check("R1 flag", {31'b0, legacy_off}, 32'h0);
        check("R1 pulses", {29'b0, gpe_status_pulse, modern_plug_valid, rsp_valid}, 32'h0);
    endtask

    task automatic do_read(input int a, input int s, input string req);
        logic [31:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        req_addr = 5'(a); req_size = 2'(s);
        e = exp_read(a, s);
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {31'b0, req_ready}, 32'h1);
        check(req, {31'b0, rsp_valid}, m_flag ? 32'h0 : 32'h1);
        check(req, rsp_rdata, m_flag ? 32'h0 : e);
    endtask

    task automatic do_write(input int a, input int s, input logic [31:0] d, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = 5'(a); req_size = 2'(s); req_wdata = d;
        if (a == 0 && d[7:0] == 8'h00) m_flag = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {31'b0, legacy_off}, {31'b0, m_flag});
    endtask

    task automatic do_plug(input int id, input string req);
        bit inr = (id < SLOTS);
        @(negedge clk);
        plug_valid = 1'b1; plug_id = ID_W'(id);
        @(negedge clk);
        plug_valid = 1'b0;
        if (inr) m_bits[id] = 1'b1; else m_flag = 1'b1;
        check(req, {31'b0, gpe_status_pulse}, {31'b0, inr});
        check(req, {31'b0, modern_plug_valid}, {31'b0, !inr});
        if (!inr) check(req, {23'b0, modern_plug_id}, 32'(id));
        check(req, {31'b0, legacy_off}, {31'b0, m_flag});
        @(negedge clk);
        check(req, {30'b0, gpe_status_pulse, modern_plug_valid}, 32'h0);
    endtask

    initial begin
        logic [31:0] e;
        void'($urandom(32'd1234));
        for (int i = 0; i < SLOTS; i++) init_present[i] = (i % 5 == 0);
        m_bits = init_present;
        m_flag = 1'b0;
        do_reset();

        // R1/R2: initial map visible by byte
        do_read(0, 0, "R1 byte0");
        do_read(31, 0, "R2 byte31");
        do_read(29, 3, "R3 tail lanes zero");
        do_read(4, 2, "R3 three bytes");

        // R6/R2: directed plugs at edges
        do_plug(1, "R6 id1");
        do_read(0, 0, "R2 id1 bit1 byte0");
        do_plug(255, "R6 id255");
        do_read(31, 0, "R2 id255 bit7 byte31");
        do_plug(0, "R6 id0 already set");

        // random traffic, no mode switch
        for (int n = 0; n < 300; n++) begin
            int op = $urandom_range(0, 2);
            if (op == 0) begin
                do_plug($urandom_range(0, SLOTS - 1), "R6 random plug");
            end else if (op == 1) begin
                do_read($urandom_range(0, 31), $urandom_range(0, 3), "R3 random read");
            end else begin
                int a = $urandom_range(1, 31);
                do_write(a, $urandom_range(0, 3), $urandom, "R5 random write ignored");
                do_read(a, 0, "R4 write leaves byte");
            end
        end

        // R5 negatives
        do_write(0, 3, 32'h0000_0001, "R5 nonzero lane0");
        do_write(1, 0, 32'h0, "R5 zero at offset1");
        do_read(0, 3, "R4 after writes");

        // R11: plug and read in same cycle
        @(negedge clk);
        e = exp_read(12, 0);
        plug_valid = 1'b1; plug_id = 9'd98;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 5'd12; req_size = 2'd0;
        @(negedge clk);
        plug_valid = 1'b0; req_valid = 1'b0;
        m_bits[98] = 1'b1;
        check("R11 old byte", rsp_rdata, e);
        check("R11 pulse", {31'b0, gpe_status_pulse}, 32'h1);
        do_read(12, 0, "R11 new byte");

        // R10 (no switch): plug with a plain write
        @(negedge clk);
        plug_valid = 1'b1; plug_id = 9'd131;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 5'd16; req_wdata = 32'h0;
        @(negedge clk);
        plug_valid = 1'b0; req_valid = 1'b0;
        m_bits[131] = 1'b1;
        check("R10 pulse", {31'b0, gpe_status_pulse}, 32'h1);
        do_read(16, 0, "R10 bit131 set");

        // R7: out-of-range plug
        do_plug(300, "R7 oob");
        do_read(0, 3, "R9 no response");
        do_plug(5, "R8 plug after switch");
        do_write(0, 0, 32'h11, "R8 flag holds");
        do_read(7, 1, "R9 still silent");

        // R8: reset clears, R1 map restored
        do_reset();
        do_read(0, 3, "R1 map restored");
        do_plug(511, "R7 max id");

        // R5 positive: 4-byte write with lane0 zero
        do_reset();
        do_write(0, 3, 32'hFFFF_FF00, "R5 zero lane0 wide");
        do_read(0, 0, "R9 after write switch");

        // R10: plug and qualifying write together
        do_reset();
        @(negedge clk);
        plug_valid = 1'b1; plug_id = 9'd7;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 5'd0; req_size = 2'd0; req_wdata = 32'h0;
        @(negedge clk);
        plug_valid = 1'b0; req_valid = 1'b0;
        m_flag = 1'b1;
        check("R10 pulse with switch", {31'b0, gpe_status_pulse}, 32'h1);
        check("R10 flag", {31'b0, legacy_off}, 32'h1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule